// File: doc/BRIEF.md
# PCM Serial Frame Port

This block connects a two-channel companded-audio serial bus to a parallel sample interface. An external bit clock and a frame sync set the timing. In every frame the block collects one 8-bit sample from each of two serial inputs: a near-end lane and a far-end lane. It presents both samples together with a single-cycle valid strobe. It also shifts out one parallel byte on each of the two serial outputs.

Bit clock, frame sync and serial data all arrive asynchronously to the system clock. Each passes through a synchronizer, and the block detects bit-clock edges in the system-clock domain. A serial output is enabled only during the eight bit periods of its byte window. At all other times the enable is low, so the pad releases the line.

A through mode sends each lane's most recently received byte back out on the same lane, in place of the parallel transmit word. The mode input and the transmit words are taken only at the start of a frame.

Top module: `pcm_frame_port`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge, `sd_oe`, both serial outputs, `rx_valid` and both receive words are 0 from that edge on. After reset, both receive words and the through-mode source bytes are 0x00.
- R2: A frame starts at a bit-clock rising edge where `pcm_fsync` is high and was low at the previous bit-clock rising edge. The serial inputs are sampled on the next eight bit-clock falling edges. The first sampled bit is bit 7 (MSB) and the last is bit 0.
- R3: After the eighth bit of a frame is captured, `rx_valid` is high for exactly one `clk` cycle. In that same cycle the new bytes appear on `near_rx_data` and `far_rx_data`. The receive words change at no other time.
- R4: The transmit byte is sent MSB first. Bit 7 is driven after the start rising edge, and each later bit is driven after the following bit-clock rising edge. Every bit is stable at the falling edge that follows it.
- R5: `sd_oe` is high from the start rising edge until the eighth bit-clock rising edge after it, and low at all other times. While `sd_oe` is low, both serial outputs are 0.
- R6: When `thru_en` is high at a frame start, each lane sends the last complete byte it received in place of its parallel transmit word.
- R7: A change of `thru_en` after a frame has started has no effect on that frame. It takes effect at the next frame start.
- R8: The transmit words are captured at frame start. A change to them during a frame does not alter the bits being sent.
- R9: A new frame start that arrives before the eighth bit restarts the bit count. The partial byte is discarded, no strobe is given for it, and the receive words keep their previous value until the next complete byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pcm_bclk | input | 1 | Serial bit clock (asynchronous) |
| pcm_fsync | input | 1 | Frame sync, high at the first bit period |
| thru_en | input | 1 | Through-mode select, taken at frame start |
| near_sd_i | input | 1 | Near-end serial data input |
| far_sd_i | input | 1 | Far-end serial data input |
| near_tx_data | input | SAMPLE_W | Near-end byte to transmit |
| far_tx_data | input | SAMPLE_W | Far-end byte to transmit |
| near_sd_o | output | 1 | Near-end serial data output |
| far_sd_o | output | 1 | Far-end serial data output |
| sd_oe | output | 1 | Output enable for both serial outputs (low = line released) |
| near_rx_data | output | SAMPLE_W | Last complete near-end byte |
| far_rx_data | output | SAMPLE_W | Last complete far-end byte |
| rx_valid | output | 1 | One-cycle strobe when new bytes are present |

## Verification
The bench runs bytes with opposite bit patterns on the two lanes. A design that swaps the lanes or reverses the bit order shows the wrong byte. The bench reads the enable in every bit period, including two idle periods. A design whose window ends one edge early or late is caught by a mismatched enable pattern.

The bench cuts a frame off with a new sync after four bits. A design that does not restart either emits an extra strobe or assembles a mixed byte. The bench also changes the mode input and the transmit words partway through a frame. A design that does not latch them at frame start corrupts the bits already in flight. Finally, a reset in the middle of a frame must release the line at once, and the following through-mode frame must send 0x00.

// File: rtl/pcm_port_pkg.sv
// Shared constants and types for the PCM serial frame port.
package pcm_port_pkg;
    localparam int unsigned LANES = 2;
    localparam int unsigned NEAR  = 0;
    localparam int unsigned FAR   = 1;

    // Single-cycle events derived from the bit clock and frame sync.
    typedef struct packed {
        logic rise;   // bit clock rising edge seen
        logic fall;   // bit clock falling edge seen
        logic start;  // frame start (rise with newly high sync)
    } pcm_tick_t;
endpackage

// File: rtl/pcm_edge_sync.sv
// Synchronizes bit clock, frame sync and serial data into the system clock
// domain and turns them into single-cycle tick events.
// Assumes each bit-clock phase lasts at least three system clock cycles.
// All signals share one synchronizer depth, so the data stays aligned with
// the clock edges.
module pcm_edge_sync
    import pcm_port_pkg::*;
#(
    parameter int STAGES = 2,
    parameter int N_DATA = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_i,
    input  logic              fsync_i,
    input  logic [N_DATA-1:0] sd_i,
    output pcm_tick_t         tick,
    output logic [N_DATA-1:0] sd_s
);
    localparam int W = N_DATA + 2;
    localparam int BCLK_BIT  = N_DATA;
    localparam int FSYNC_BIT = N_DATA + 1;

    logic [STAGES-1:0][W-1:0] stage_q;
    logic bclk_s, fsync_s, bclk_d, fsync_at_rise;

    // Synchronizer chain for all asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= {fsync_i, bclk_i, sd_i};
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign bclk_s  = stage_q[STAGES-1][BCLK_BIT];
    assign fsync_s = stage_q[STAGES-1][FSYNC_BIT];
    assign sd_s    = stage_q[STAGES-1][N_DATA-1:0];

    // Previous bit clock level and sync level at the last rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_d        <= 1'b0;
            fsync_at_rise <= 1'b0;
        end else begin
            bclk_d <= bclk_s;
            if (bclk_s && !bclk_d) fsync_at_rise <= fsync_s;
        end
    end

    assign tick.rise  = bclk_s & ~bclk_d;
    assign tick.fall  = ~bclk_s & bclk_d;
    assign tick.start = bclk_s & ~bclk_d & fsync_s & ~fsync_at_rise;
endmodule

// File: rtl/pcm_frame_ctrl.sv
// Frame sequencer: tracks the byte window, counts transmitted and captured
// bits, and produces load/shift/capture strokes shared by all lanes.
// Assumes ticks come from pcm_edge_sync. A start always wins over ongoing
// counting.
module pcm_frame_ctrl
    import pcm_port_pkg::*;
#(
    parameter int SAMPLE_W = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  pcm_tick_t tick,
    output logic      win,
    output logic      tx_load,
    output logic      tx_shift,
    output logic      cap_en,
    output logic      cap_done,
    output logic      rx_valid
);
    localparam int CW = (SAMPLE_W > 1) ? $clog2(SAMPLE_W) : 1;
    localparam logic [CW-1:0] LAST = CW'(SAMPLE_W - 1);

    logic [CW-1:0] tx_pos, rx_cnt;

    assign tx_load  = tick.start;
    assign tx_shift = tick.rise & win & ~tick.start & (tx_pos != LAST);
    assign cap_en   = tick.fall & win;
    assign cap_done = cap_en & (rx_cnt == LAST);

    // Output window and position of the bit being driven.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win    <= 1'b0;
            tx_pos <= '0;
        end else if (tick.start) begin
            win    <= 1'b1;
            tx_pos <= '0;
        end else if (tick.rise && win) begin
            if (tx_pos == LAST) win <= 1'b0;
            else                tx_pos <= tx_pos + 1'b1;
        end
    end

    // Count of captured bits; a restart discards a partial byte.
    always_ff @(posedge clk) begin
        if (!rst_n || tick.start) begin
            rx_cnt <= '0;
        end else if (cap_en) begin
            rx_cnt <= cap_done ? '0 : rx_cnt + 1'b1;
        end
    end

    // One-cycle strobe aligned with publication of the received bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_valid <= 1'b0;
        else        rx_valid <= cap_done;
    end
endmodule

// File: rtl/pcm_lane.sv
// One serial lane: deserializes the input, holds the last complete byte and
// serializes either the parallel word or, in through mode, that held byte.
// Assumes strokes from pcm_frame_ctrl; load and capture never coincide.
module pcm_lane #(
    parameter int SAMPLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sd_s,
    input  logic [SAMPLE_W-1:0] tx_word,
    input  logic                thru,
    input  logic                tx_load,
    input  logic                tx_shift,
    input  logic                cap_en,
    input  logic                cap_done,
    input  logic                win,
    output logic                sd_o,
    output logic [SAMPLE_W-1:0] rx_word
);
    logic [SAMPLE_W-2:0] rx_sr;
    logic [SAMPLE_W-1:0] rx_next, tx_sr;

    assign rx_next = {rx_sr, sd_s};

    // Input shift register, MSB arrives first.
    always_ff @(posedge clk) begin
        if (!rst_n)      rx_sr <= '0;
        else if (cap_en) rx_sr <= rx_next[SAMPLE_W-2:0];
    end

    // Publish a byte only when its last bit is captured.
    always_ff @(posedge clk) begin
        if (!rst_n)        rx_word <= '0;
        else if (cap_done) rx_word <= rx_next;
    end

    // Output shift register, loaded at frame start from the selected source.
    always_ff @(posedge clk) begin
        if (!rst_n)        tx_sr <= '0;
        else if (tx_load)  tx_sr <= thru ? rx_word : tx_word;
        else if (tx_shift) tx_sr <= {tx_sr[SAMPLE_W-2:0], 1'b0};
    end

    assign sd_o = win & tx_sr[SAMPLE_W-1];
endmodule

// File: rtl/pcm_frame_port.sv
// Two-lane PCM serial frame port. Moves one byte per lane per frame between
// the serial bus and parallel words, with an optional through mode.
// Assumes clk runs at least six times faster than the bit clock.
module pcm_frame_port
    import pcm_port_pkg::*;
#(
    parameter int SAMPLE_W    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pcm_bclk,
    input  logic                pcm_fsync,
    input  logic                thru_en,
    input  logic                near_sd_i,
    input  logic                far_sd_i,
    input  logic [SAMPLE_W-1:0] near_tx_data,
    input  logic [SAMPLE_W-1:0] far_tx_data,
    output logic                near_sd_o,
    output logic                far_sd_o,
    output logic                sd_oe,
    output logic [SAMPLE_W-1:0] near_rx_data,
    output logic [SAMPLE_W-1:0] far_rx_data,
    output logic                rx_valid
);
    pcm_tick_t tick;
    logic win, tx_load, tx_shift, cap_en, cap_done;
    logic [LANES-1:0] sd_in_s, sd_out;
    logic [LANES-1:0][SAMPLE_W-1:0] tx_word, rx_word;

    pcm_edge_sync #(.STAGES(SYNC_STAGES), .N_DATA(LANES)) u_sync (
        .clk(clk), .rst_n(rst_n), .bclk_i(pcm_bclk), .fsync_i(pcm_fsync),
        .sd_i({far_sd_i, near_sd_i}), .tick(tick), .sd_s(sd_in_s)
    );

    pcm_frame_ctrl #(.SAMPLE_W(SAMPLE_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .win(win),
        .tx_load(tx_load), .tx_shift(tx_shift), .cap_en(cap_en),
        .cap_done(cap_done), .rx_valid(rx_valid)
    );

    assign tx_word[NEAR] = near_tx_data;
    assign tx_word[FAR]  = far_tx_data;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pcm_lane #(.SAMPLE_W(SAMPLE_W)) u_lane (
            .clk(clk), .rst_n(rst_n), .sd_s(sd_in_s[g]), .tx_word(tx_word[g]),
            .thru(thru_en), .tx_load(tx_load), .tx_shift(tx_shift),
            .cap_en(cap_en), .cap_done(cap_done), .win(win),
            .sd_o(sd_out[g]), .rx_word(rx_word[g])
        );
    end

    assign near_sd_o    = sd_out[NEAR];
    assign far_sd_o     = sd_out[FAR];
    assign near_rx_data = rx_word[NEAR];
    assign far_rx_data  = rx_word[FAR];
    assign sd_oe        = win;
endmodule

// File: rtl/pcm_frame_port_chk.sv
// Property checker for pcm_frame_port, attached with bind below.
module pcm_frame_port_chk #(
    parameter int SAMPLE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sd_oe,
    input logic                rx_valid,
    input logic [SAMPLE_W-1:0] near_rx_data,
    input logic [SAMPLE_W-1:0] far_rx_data
);
    logic rst_seen_low;

    // Remember that reset was low at the previous edge.
    always_ff @(posedge clk) rst_seen_low <= !rst_n;

    // R1
    always_ff @(posedge clk) begin
        if (rst_seen_low === 1'b1) begin
            reset_quiet_chk: assert (!sd_oe && !rx_valid && near_rx_data == '0 && far_rx_data == '0)
                else $error("outputs active after reset edge");
        end
    end

    // R3
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid)
        else $error("rx_valid longer than one cycle");

    // R3
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> ($stable(near_rx_data) && $stable(far_rx_data)))
        else $error("receive word changed without strobe");

    // R2
    valid_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> sd_oe)
        else $error("strobe outside the byte window");
endmodule

bind pcm_frame_port pcm_frame_port_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (.*);

// File: tb/sim_pcm_frame_port.sv
// Directed bench for pcm_frame_port: one task per scenario.
module sim_pcm_frame_port;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int WD_CYCLES  = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pcm_bclk = 1'b0, pcm_fsync = 1'b0, thru_en = 1'b0;
    logic near_sd_i = 1'b0, far_sd_i = 1'b0;
    logic [7:0] near_tx_data = 8'h00, far_tx_data = 8'h00;
    logic near_sd_o, far_sd_o, sd_oe, rx_valid;
    logic [7:0] near_rx_data, far_rx_data;

    int checks = 0, fails = 0, vcount = 0;
    logic [7:0] obs_n, obs_f;
    logic [15:0] obs_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcm_frame_port u0 (
        .clk(clk), .rst_n(rst_n), .pcm_bclk(pcm_bclk), .pcm_fsync(pcm_fsync),
        .thru_en(thru_en), .near_sd_i(near_sd_i), .far_sd_i(far_sd_i),
        .near_tx_data(near_tx_data), .far_tx_data(far_tx_data),
        .near_sd_o(near_sd_o), .far_sd_o(far_sd_o), .sd_oe(sd_oe),
        .near_rx_data(near_rx_data), .far_rx_data(far_rx_data), .rx_valid(rx_valid)
    );

    // Count strobe cycles seen between edges.
    always @(negedge clk) if (rx_valid === 1'b1) vcount++;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive a number of bit periods; period 0 carries the sync.
    task automatic run_frame(input int periods, input logic [7:0] sn, input logic [7:0] sf,
                             input int hook_at, input logic hook_thru,
                             input logic [7:0] hook_tn, input logic [7:0] hook_tf);
        obs_n = '0; obs_f = '0; obs_oe = '0;
        for (int i = 0; i < periods; i++) begin
            @(negedge clk);
            if (i == hook_at) begin
                thru_en = hook_thru; near_tx_data = hook_tn; far_tx_data = hook_tf;
            end
            pcm_bclk = 1'b1;
            pcm_fsync = (i == 0);
            if (i < 8) begin near_sd_i = sn[7-i]; far_sd_i = sf[7-i]; end
            else begin near_sd_i = 1'b1; far_sd_i = 1'b1; end
            repeat (HALF-1) @(negedge clk);
            if (i < 8) begin obs_n[7-i] = near_sd_o; obs_f[7-i] = far_sd_o; end
            obs_oe[i] = sd_oe;
            @(negedge clk);
            pcm_bclk = 1'b0;
            repeat (HALF-1) @(negedge clk);
        end
    endtask

    task automatic full_frame(input string req, input logic [7:0] sn, input logic [7:0] sf,
                              input logic [7:0] exp_n, input logic [7:0] exp_f);
        int v0;
        v0 = vcount;
        run_frame(10, sn, sf, -1, thru_en, near_tx_data, far_tx_data);
        chk(req, "near serial out", obs_n, exp_n);
        chk(req, "far serial out", obs_f, exp_f);
        chk("R3", "strobe count", vcount - v0, 1);
        chk("R2", "near rx", near_rx_data, sn);
        chk("R2", "far rx", far_rx_data, sf);
    endtask

    task automatic t_reset_state;
        chk("R1", "oe", sd_oe, 0);
        chk("R1", "serial outs", {near_sd_o, far_sd_o}, 0);
        chk("R1", "valid", rx_valid, 0);
        chk("R1", "rx words", {near_rx_data, far_rx_data}, 0);
    endtask

    task automatic t_basic;
        thru_en = 0;
        near_tx_data = 8'hA5; far_tx_data = 8'h3C;
        full_frame("R4", 8'h96, 8'h69, 8'hA5, 8'h3C);
        // R5 enable only in the eight data periods
        chk("R5", "oe pattern", obs_oe[9:0], 10'h0FF);
        near_tx_data = 8'hFF; far_tx_data = 8'h00;
        full_frame("R4", 8'h00, 8'hFF, 8'hFF, 8'h00);
        near_tx_data = 8'h01; far_tx_data = 8'h80;
        full_frame("R4", 8'h80, 8'h01, 8'h01, 8'h80);
        chk("R5", "oe idle after frame", sd_oe, 0);
    endtask

    task automatic t_through;
        thru_en = 0;
        near_tx_data = 8'h12; far_tx_data = 8'h34;
        full_frame("R4", 8'hC7, 8'h2E, 8'h12, 8'h34);
        thru_en = 1;
        full_frame("R6", 8'h5B, 8'hE0, 8'hC7, 8'h2E);
        full_frame("R6", 8'h0D, 8'hB1, 8'h5B, 8'hE0);
        thru_en = 0;
    endtask

    task automatic t_mode_midframe;
        int v0;
        thru_en = 0;
        near_tx_data = 8'h11; far_tx_data = 8'h22;
        v0 = vcount;
        run_frame(10, 8'h6B, 8'h94, 3, 1'b1, 8'h11, 8'h22);
        chk("R7", "near out ignores late mode", obs_n, 8'h11);
        chk("R7", "far out ignores late mode", obs_f, 8'h22);
        chk("R3", "strobe count", vcount - v0, 1);
        full_frame("R7", 8'h40, 8'h02, 8'h6B, 8'h94);
        thru_en = 0;
    endtask

    task automatic t_tx_late;
        near_tx_data = 8'h0F; far_tx_data = 8'hF0;
        run_frame(10, 8'h33, 8'hCC, 2, 1'b0, 8'hF0, 8'h0F);
        chk("R8", "near keeps captured word", obs_n, 8'h0F);
        chk("R8", "far keeps captured word", obs_f, 8'hF0);
        full_frame("R8", 8'h55, 8'hAA, 8'hF0, 8'h0F);
    endtask

    task automatic t_restart;
        int v0;
        logic [7:0] held_n, held_f;
        held_n = near_rx_data; held_f = far_rx_data;
        v0 = vcount;
        near_tx_data = 8'hE7; far_tx_data = 8'h7E;
        run_frame(4, 8'hFF, 8'hFF, -1, 1'b0, 8'hE7, 8'h7E);
        chk("R9", "no strobe for partial", vcount - v0, 0);
        chk("R9", "rx words held", {near_rx_data, far_rx_data}, {held_n, held_f});
        near_tx_data = 8'h9C; far_tx_data = 8'hC9;
        full_frame("R9", 8'h21, 8'h84, 8'h9C, 8'hC9);
        chk("R9", "oe pattern after restart", obs_oe[9:0], 10'h0FF);
    endtask

    task automatic t_reset_midframe;
        int v0;
        near_tx_data = 8'hFF; far_tx_data = 8'hFF;
        run_frame(3, 8'hAB, 8'hCD, -1, 1'b0, 8'hFF, 8'hFF);
        v0 = vcount;
        @(negedge clk); rst_n = 0;
        repeat (3) @(negedge clk);
        chk("R1", "oe during reset", sd_oe, 0);
        chk("R1", "serial outs during reset", {near_sd_o, far_sd_o}, 0);
        chk("R1", "rx cleared", {near_rx_data, far_rx_data}, 0);
        rst_n = 1;
        repeat (4) @(negedge clk);
        chk("R1", "no strobe", vcount - v0, 0);
        thru_en = 1;
        full_frame("R1", 8'h3E, 8'hE3, 8'h00, 8'h00);
        thru_en = 0;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        t_reset_state();
        rst_n = 1;
        repeat (4) @(negedge clk);
        t_reset_state();
        t_basic();
        t_through();
        t_mode_midframe();
        t_tx_late();
        t_restart();
        t_reset_midframe();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule